// File: doc/BRIEF.md
# Configurable Synchronous FIFO Queue

A single-clock first-in first-out queue that passes fixed-width words from a producer to a consumer. The producer sees a `push_ok` flag and offers a word with `push_en`. The consumer sees a `pop_ok` flag and takes the head word with `pop_en`. Words are stored in a small array of registers. Each slot is written on the clock edge and read combinationally. A write pointer, a read pointer and an occupancy count track the contents.

Two parameters select the flavour. `PIPE` lets a full queue accept a new word in the same cycle that its head word leaves. This works because the slot being read still drives its old value during the cycle in which it is overwritten. `FWFT` selects how the head word is presented. With it on, the head word is visible on `pop_data` while `pop_ok` is high. With it off, `pop_data` comes from a register that loads on an accepted pop.

At depth 1 the queue serves as a pipeline stage. With `PIPE` on it is a register stage that can stream one word per cycle. With `PIPE` off and `FWFT` on, `push_ok` does not depend on `pop_en`, so the stage cuts the combinational ready path.

Top module: `sync_queue`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the queue. After reset, `pop_ok` is 0, and `push_ok` is 1 while `pop_en` is 0.
- R2: `pop_ok` is 1 exactly when the queue holds at least one word. A pop request made while `pop_ok` is 0 is ignored and changes neither the contents nor the output.
- R3: With `PIPE` off, or with `pop_en` low, `push_ok` is 1 exactly when the queue holds fewer than `DEPTH` words. A push made while `push_ok` is 0 is ignored.
- R4: With `PIPE` on, `pop_en` high forces `push_ok` to 1, even when the queue is full. A push and a pop on a full queue in the same cycle leave it full, and the new word leaves after the words already held.
- R5: Words leave in the order in which they were accepted. The read and write pointers wrap modulo `DEPTH`, so any `DEPTH` works, including values that are not a power of two.
- R6: With `FWFT` on, `pop_data` equals the oldest stored word in every cycle in which `pop_ok` is 1, with no clock edge in between.
- R7: With `FWFT` off, `pop_data` takes the popped word at the clock edge that accepts the pop. It keeps that value until the next accepted pop.
- R8: The occupancy count rises by one on a push alone, falls by one on a pop alone, and does not change when both are accepted. With no pops, `push_ok` falls after exactly `DEPTH` accepted pushes.
- R9: With `DEPTH` = 1, `PIPE` off and `FWFT` on, `push_ok` of a full queue stays 0 whatever the value of `pop_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Producer offers `push_data` |
| push_data | input | DATA_W | Word to store |
| push_ok | output | 1 | Queue can accept a push this cycle |
| pop_en | input | 1 | Consumer takes the head word |
| pop_data | output | DATA_W | Head word (FWFT) or last popped word (registered) |
| pop_ok | output | 1 | Queue holds at least one word |

## Verification
A wrong pointer or occupancy count shows up quickly at the ports. With FWFT on, `pop_data` shows a word out of order in the same cycle the head changes. In every configuration, `pop_ok` or `push_ok` flips at the wrong fill level within the next few fills or drains. A word dropped or duplicated on a simultaneous push and pop on a full queue first shows as a wrong word when that slot is drained. That takes at most `DEPTH` pops. With registered output, the error shows one cycle after the pop that reads the slot. Five configurations are swept with biased random traffic, so the queue is filled and drained many times. Each cycle is compared with a queue model kept in the bench.

// File: rtl/queue_pkg.sv
package queue_pkg;

    // Width of an index into n slots, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must reach n.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/queue_ctrl.sv
module queue_ctrl #(
    parameter int DEPTH = 4,
    parameter bit PIPE  = 1'b1,
    parameter int PTR_W = queue_pkg::idx_w(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic             pop_en,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             push_acc,
    output logic             pop_acc,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);
    localparam int CNT_W = queue_pkg::cnt_w(DEPTH);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] fill;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  full_d, empty_d;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        full_d   = (st_q.fill == FULL_CNT);
        empty_d  = (st_q.fill == '0);
        pop_ok   = !empty_d;
        push_ok  = !full_d || (PIPE && pop_en);
        pop_acc  = pop_en && pop_ok;
        push_acc = push_en && push_ok;
        if (push_acc) st_d.wptr = step(st_q.wptr);
        if (pop_acc)  st_d.rptr = step(st_q.rptr);
        unique case ({push_acc, pop_acc})
            2'b10:   st_d.fill = st_q.fill + 1'b1;
            2'b01:   st_d.fill = st_q.fill - 1'b1;
            default: st_d.fill = st_q.fill;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_ptr = st_q.wptr;
    assign rd_ptr = st_q.rptr;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.fill <= FULL_CNT);

    // R8
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_acc == pop_acc) |=> $stable(st_q.fill));

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !pop_ok) |=> $stable(st_q.rptr));

    // R3
    full_push_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && !push_ok) |=> $stable(st_q.wptr));

endmodule

// File: rtl/queue_store.sv
module queue_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int PTR_W  = queue_pkg::idx_w(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(s))) slot_q[s] <= wr_data;
        end
    end

    // Combinational read: old contents remain visible during a write cycle.
    assign rd_data = slot_q[rd_addr];

endmodule

// File: rtl/queue_out.sv
module queue_out #(
    parameter int DATA_W = 8,
    parameter bit FWFT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_acc,
    input  logic [DATA_W-1:0] head,
    output logic [DATA_W-1:0] pop_data
);
    if (FWFT) begin : g_fall
        assign pop_data = head;
    end else begin : g_reg
        logic [DATA_W-1:0] dout_d, dout_q;

        always_comb begin
            dout_d = dout_q;
            if (pop_acc) dout_d = head;
        end

        always_ff @(posedge clk) begin
            if (rst) dout_q <= '0;
            else     dout_q <= dout_d;
        end

        assign pop_data = dout_q;

        // R7
        dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !pop_acc |=> $stable(dout_q));
    end

endmodule

// File: rtl/sync_queue.sv
module sync_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter bit PIPE   = 1'b1,
    parameter bit FWFT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ok,
    input  logic              pop_en,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_ok
);
    localparam int PTR_W = queue_pkg::idx_w(DEPTH);

    logic             push_acc, pop_acc;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [DATA_W-1:0] head;

    queue_ctrl #(.DEPTH(DEPTH), .PIPE(PIPE), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst(rst), .push_en(push_en), .pop_en(pop_en),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .push_acc(push_acc), .pop_acc(pop_acc),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    queue_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk(clk), .wr_en(push_acc), .wr_addr(wr_ptr), .wr_data(push_data),
        .rd_addr(rd_ptr), .rd_data(head)
    );

    queue_out #(.DATA_W(DATA_W), .FWFT(FWFT)) u_out (
        .clk(clk), .rst(rst), .pop_acc(pop_acc), .head(head),
        .pop_data(pop_data)
    );

    // R4
    pipe_force_chk: assert property (@(posedge clk) disable iff (rst)
        (PIPE && pop_en) |-> push_ok);

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (!pop_ok && (push_ok || pop_en)));

endmodule

// File: tb/sim_sync_queue.sv
module sim_sync_queue;
    localparam int NCFG  = 5;
    localparam int STEPS = 2000;
    localparam int DEP [NCFG] = '{4, 3, 1, 1, 1};
    localparam int PIP [NCFG] = '{1, 0, 1, 0, 1};
    localparam int FWT [NCFG] = '{1, 0, 1, 1, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   fails  = 0;
    int   done   = 0;

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int cfg,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cfg=%0d act=%0d exp=%0d", tag, cfg, act, exp);
        end
    endtask

    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        localparam int D = DEP[k];
        logic       we = 1'b0, re = 1'b0;
        logic [7:0] wd = '0;
        logic [7:0] rdat;
        logic       wok, rok;

        sync_queue #(.DATA_W(8), .DEPTH(D), .PIPE(PIP[k] != 0),
                     .FWFT(FWT[k] != 0)) u0 (
            .clk(clk), .rst(rst), .push_en(we), .push_data(wd),
            .push_ok(wok), .pop_en(re), .pop_data(rdat), .pop_ok(rok)
        );

        initial begin
            logic [7:0] mq[$];
            logic [7:0] dexp;
            bit         dval;
            dval = 1'b0;
            dexp = '0;
            repeat (4) @(negedge clk);
            #1;
            // R1: empty after reset
            chk(rok == 1'b0, "R1", k, int'(rok), 0);
            chk(wok == 1'b1, "R1", k, int'(wok), 1);
            for (int i = 0; i < STEPS; i++) begin
                int  pw, pr;
                bit  e_rd, e_wr, racc, wacc;
                string wtag;
                if (i > 0) @(negedge clk);
                pw = ((i / 48) % 2 == 0) ? 80 : 25;
                pr = ((i / 48) % 2 == 0) ? 35 : 85;
                we = (($urandom % 100) < pw);
                re = (($urandom % 100) < pr);
                wd = 8'($urandom);
                #1;
                e_rd = (mq.size() > 0);
                e_wr = (mq.size() < D) || ((PIP[k] != 0) && re);
                // R2
                chk(rok == e_rd, "R2", k, int'(rok), int'(e_rd));
                if (D == 1 && PIP[k] == 0)                   wtag = "R9";
                else if (PIP[k] != 0 && re && mq.size() == D) wtag = "R4";
                else if (mq.size() == D)                      wtag = "R8";
                else                                          wtag = "R3";
                chk(wok == e_wr, wtag, k, int'(wok), int'(e_wr));
                if (FWT[k] != 0 && e_rd)
                    // R5 R6: head word in order, combinational
                    chk(rdat == mq[0], "R5 R6", k, int'(rdat), int'(mq[0]));
                if (FWT[k] == 0 && dval)
                    // R7: registered word, held between pops
                    chk(rdat == dexp, "R7", k, int'(rdat), int'(dexp));
                racc = re && e_rd;
                wacc = we && e_wr;
                if (racc) begin
                    dexp = mq.pop_front();
                    dval = 1'b1;
                end
                if (wacc) mq.push_back(wd);
            end
            @(negedge clk);
            we = 1'b0;
            re = 1'b0;
            done++;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        fork
            wait (done == NCFG);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog act=%0d exp=%0d", done, NCFG);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule